// File: doc/BRIEF.md
# Cross-Clock Cycle Termination Synchronizer

This block ends bus cycles for a fast processor (about 16 MHz) that has been placed on an older 16-bit bus running from a slower clock (about 7.16 MHz). The old bus signals the end of a transfer with an asynchronous, active-low transfer acknowledge. A slow peripheral-cycle sequencer raises a separate termination flag when its long cycle is done. The block turns either event into the processor's two-wire port-size acknowledge. The legacy bus is always reported as a 16-bit port.

A legacy acknowledge is not trusted when it first appears. It counts only after the delayed address strobe has been seen active at two earlier slow edges. This rejects acknowledges that come back too early and short glitches. A qualified event is then sampled only in a reference phase, which repeats every second slow edge. It sets a flag in the slow domain, and one register on the fast clock carries that flag across. The flag clears when the strobe goes away. The coprocessor and an expansion static RAM port have their own acknowledges. These are merged straight into the outputs.

Top module: `bus_ack_bridge`

## Requirements
- R1: The outputs are active low and form a pair {dsack1_n, dsack0_n}. The codes are 00 = 32-bit port, 01 = 16-bit port, 10 = 8-bit port and 11 = wait. dsack1_n is low when the synchronized legacy acknowledge, cp_dsack1_n or sram_dsack1_n is asserted. dsack0_n is low only when cp_dsack0_n or sram_dsack0_n is low.
- R2: A cycle acknowledged by the legacy path alone shows code 01 (16-bit). dsack0_n stays high.
- R3: The slow-domain acknowledge can be set only at odd-numbered rising edges of clk_slow, counted from reset release. The first edge after release is edge 1. An event that is ready at an even edge waits for the next edge.
- R4: A low dtack_n counts at a clk_slow edge only when as_dly_n is low at that edge and was also low at the two previous edges.
- R5: A dtack_n that is low only at the first two clk_slow edges of a strobe, and high afterwards, produces no acknowledge.
- R6: A high term_flag at a clk_slow edge where as_dly_n is low counts as an acknowledge event. It needs no qualifier wait.
- R7: Once the slow-domain acknowledge is set, dsack1_n goes low at the next clk_fast rising edge.
- R8: The slow-domain acknowledge clears at the first clk_slow edge with as_dly_n high. dsack1_n returns high at the first clk_fast edge with cpu_as_n high.
- R9: During reset, and after reset with no activity, both outputs read 11.
- R10: With as_dly_n high, neither dtack_n nor term_flag produces an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Legacy bus clock (about 7.16 MHz) |
| clk_fast | input | 1 | Processor clock (about 16 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_as_n | input | 1 | Processor address strobe, active low, in the fast domain |
| as_dly_n | input | 1 | Delayed address strobe, active low, aligned to clk_slow |
| dtack_n | input | 1 | Legacy transfer acknowledge, active low |
| term_flag | input | 1 | Peripheral-cycle termination flag, active high, aligned to clk_slow |
| cp_dsack1_n | input | 1 | Coprocessor 16-bit acknowledge, active low |
| cp_dsack0_n | input | 1 | Coprocessor 8-bit acknowledge, active low |
| sram_dsack1_n | input | 1 | Static RAM port 16-bit acknowledge, active low |
| sram_dsack0_n | input | 1 | Static RAM port 8-bit acknowledge, active low |
| dsack1_n | output | 1 | Merged acknowledge wire 1, active low |
| dsack0_n | output | 1 | Merged acknowledge wire 0, active low |

## Verification
A slow-domain acknowledge that is set too early would show as a dsack1_n low one or two slow periods before the qualified edge. A slow-domain acknowledge set in the wrong reference phase would show one slow period off. The bench samples each slow period just before the next edge, so either error is caught in the cycle where it happens. A fast register that does not clear would keep dsack1_n low past the first fast edge after the strobe is negated. A qualifier chain that is too short would acknowledge the early-response pattern within three slow edges.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

  // Pair code {dsack1_n, dsack0_n}
  localparam logic [1:0] CODE_PORT32 = 2'b00;
  localparam logic [1:0] CODE_PORT16 = 2'b01;
  localparam logic [1:0] CODE_PORT8  = 2'b10;
  localparam logic [1:0] CODE_WAIT   = 2'b11;

  // Inputs are active high here; result is the active-low wire pair.
  function automatic logic [1:0] merge_ack(input logic legacy_ack,
                                           input logic cp_w1, input logic cp_w0,
                                           input logic sr_w1, input logic sr_w0);
    logic w1;
    logic w0;
    w1 = legacy_ack | cp_w1 | sr_w1;
    w0 = cp_w0 | sr_w0;
    return {~w1, ~w0};
  endfunction

endpackage

// File: rtl/ref_phase_gen.sv
module ref_phase_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ref_active
);
  logic half_q;

  // Halved slow clock; active window is the low half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign ref_active = ~half_q;

  assert_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |=> !half_q);
endmodule

// File: rtl/ack_qualifier.sv
module ack_qualifier #(
  parameter int QUAL_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic as_dly_n,
  input  logic dtack_n,
  input  logic term_flag,
  input  logic ref_active,
  output logic sys_ack
);
  logic                   strobe_on;
  logic [QUAL_STAGES-1:0] qual_q;
  logic                   qual_all;
  logic                   dtack_term;
  logic                   prelim;
  logic                   trigger;
  logic                   sys_ack_q;

  assign strobe_on = ~as_dly_n;

  // Qualifier chain: each stage is the strobe delayed by one more slow edge.
  generate
    for (genvar g = 0; g < QUAL_STAGES; g++) begin : g_qual
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) qual_q[0] <= 1'b0;
          else        qual_q[0] <= strobe_on;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) qual_q[g] <= 1'b0;
          else        qual_q[g] <= strobe_on & qual_q[g-1];
        end
      end
    end
  endgenerate

  assign qual_all   = &qual_q;
  assign dtack_term = ~dtack_n & strobe_on & qual_all;
  assign prelim     = term_flag | dtack_term;
  assign trigger    = prelim & ref_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sys_ack_q <= 1'b0;
    else if (!strobe_on) sys_ack_q <= 1'b0;
    else if (trigger)    sys_ack_q <= 1'b1;
  end

  assign sys_ack = sys_ack_q;

  assert_set_in_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_ack_q) |-> $past(ref_active));
  assert_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_ack_q) |-> $past(term_flag || (qual_all && !dtack_n)));
  assert_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_ack_q) |-> $past(!as_dly_n));
  assert_slow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    as_dly_n |=> !sys_ack_q);
endmodule

// File: rtl/fast_resync.sv
module fast_resync #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_as_n,
  input  logic sys_ack,
  output logic ack_fast
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      logic d_in;
      if (g == 0) begin : g_src
        assign d_in = sys_ack;
      end else begin : g_chain
        assign d_in = sync_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sync_q[g] <= 1'b0;
        else if (cpu_as_n) sync_q[g] <= 1'b0;
        else               sync_q[g] <= d_in;
      end
    end
  endgenerate

  assign ack_fast = sync_q[SYNC_STAGES-1];

  assert_fast_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_as_n |=> !ack_fast);
endmodule

// File: rtl/bus_ack_bridge.sv
module bus_ack_bridge #(
  parameter int QUAL_STAGES = 2,
  parameter int SYNC_STAGES = 1
) (
  input  logic clk_slow,
  input  logic clk_fast,
  input  logic rst_n,
  input  logic cpu_as_n,
  input  logic as_dly_n,
  input  logic dtack_n,
  input  logic term_flag,
  input  logic cp_dsack1_n,
  input  logic cp_dsack0_n,
  input  logic sram_dsack1_n,
  input  logic sram_dsack0_n,
  output logic dsack1_n,
  output logic dsack0_n
);
  import bus_ack_pkg::*;

  logic ref_active;
  logic sys_ack;
  logic ack_fast;
  logic [1:0] pair_code;

  ref_phase_gen u_phase (
    .clk(clk_slow), .rst_n(rst_n), .ref_active(ref_active)
  );

  ack_qualifier #(.QUAL_STAGES(QUAL_STAGES)) u_qual (
    .clk(clk_slow), .rst_n(rst_n), .as_dly_n(as_dly_n), .dtack_n(dtack_n),
    .term_flag(term_flag), .ref_active(ref_active), .sys_ack(sys_ack)
  );

  fast_resync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .cpu_as_n(cpu_as_n),
    .sys_ack(sys_ack), .ack_fast(ack_fast)
  );

  assign pair_code = merge_ack(ack_fast, ~cp_dsack1_n, ~cp_dsack0_n,
                               ~sram_dsack1_n, ~sram_dsack0_n);
  assign dsack1_n  = pair_code[1];
  assign dsack0_n  = pair_code[0];

  assert_legacy_16_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (ack_fast && cp_dsack0_n && sram_dsack0_n) |-> ({dsack1_n, dsack0_n} == CODE_PORT16));
  assert_w0_source_R1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (cp_dsack0_n && sram_dsack0_n) |-> dsack0_n);
endmodule

// File: tb/bus_ack_bridge_tb_top.sv
module bus_ack_bridge_tb_top;
  localparam int FAST_PERIOD = 62;
  localparam int SLOW_PERIOD = 140;
  localparam int SETTLE      = 130;

  logic clk_slow = 1'b0, clk_fast = 1'b0, rst_n = 1'b0;
  logic cpu_as_n = 1'b1, as_dly_n = 1'b1, dtack_n = 1'b1, term_flag = 1'b0;
  logic cp_dsack1_n = 1'b1, cp_dsack0_n = 1'b1, sram_dsack1_n = 1'b1, sram_dsack0_n = 1'b1;
  logic dsack1_n, dsack0_n;

  always #(SLOW_PERIOD/2) clk_slow = ~clk_slow;
  always #(FAST_PERIOD/2) clk_fast = ~clk_fast;

  bus_ack_bridge dut_i (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst_n(rst_n),
    .cpu_as_n(cpu_as_n), .as_dly_n(as_dly_n), .dtack_n(dtack_n), .term_flag(term_flag),
    .cp_dsack1_n(cp_dsack1_n), .cp_dsack0_n(cp_dsack0_n),
    .sram_dsack1_n(sram_dsack1_n), .sram_dsack0_n(sram_dsack0_n),
    .dsack1_n(dsack1_n), .dsack0_n(dsack0_n)
  );

  typedef struct { string tag; logic [1:0] pair; } exp_item_t;
  exp_item_t exp_q[$];
  event sample_ev;
  int n_checks = 0, n_fail = 0;
  int slow_edges = 0;
  bit done = 1'b0;

  always @(posedge clk_slow) if (rst_n) slow_edges <= slow_edges + 1;

  // Monitor: pops expectations and compares with the ports.
  initial begin
    forever begin
      @(sample_ev);
      #0;
      while (exp_q.size() > 0) begin
        exp_item_t it;
        it = exp_q.pop_front();
        n_checks++;
        if ({dsack1_n, dsack0_n} !== it.pair) begin
          n_fail++;
          $display("FAIL %s actual=%b expected=%b at %0t", it.tag, {dsack1_n, dsack0_n}, it.pair, $time);
        end
      end
    end
  end

  task automatic expect_pair(input string tag, input logic [1:0] pair);
    exp_item_t it;
    it.tag = tag; it.pair = pair;
    exp_q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic release_cycle(input string tag);
    @(negedge clk_slow);
    cpu_as_n = 1'b1; as_dly_n = 1'b1; dtack_n = 1'b1; term_flag = 1'b0;
    #(FAST_PERIOD + 5);
    expect_pair({tag, " R8 negation"}, 2'b11);
    repeat (2) @(negedge clk_slow);
  endtask

  // Legacy cycle ended by dtack (use_term=0) or by the termination flag.
  task automatic legacy_cycle(input bit use_term, input string tag);
    int n, first, e_ack;
    @(negedge clk_slow);
    n = slow_edges;
    cpu_as_n = 1'b0; as_dly_n = 1'b0;
    dtack_n = use_term; term_flag = use_term;
    first = use_term ? n + 1 : n + 3;            // R4 / R6
    e_ack = (first % 2 == 1) ? first : first + 1; // R3
    for (int idx = n + 1; idx <= e_ack; idx++) begin
      @(posedge clk_slow);
      #SETTLE;
      expect_pair({tag, (idx == e_ack) ? " R7 R2 ack 16-bit" : " R3 R4 no ack yet"},
                  (idx == e_ack) ? 2'b01 : 2'b11);
    end
    release_cycle(tag);
  endtask

  initial begin
    #(FAST_PERIOD * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(3 * SLOW_PERIOD);
    expect_pair("R9 reset state", 2'b11);
    @(negedge clk_slow);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_slow);
    expect_pair("R9 idle after reset", 2'b11);

    // Qualified dtack at both phase parities.
    legacy_cycle(1'b0, "dtack A");
    @(negedge clk_slow);
    legacy_cycle(1'b0, "dtack B");
    // Termination flag at both parities.
    legacy_cycle(1'b1, "term A");
    @(negedge clk_slow);
    legacy_cycle(1'b1, "term B");

    // R5: dtack low only during the first two edges.
    @(negedge clk_slow);
    cpu_as_n = 1'b0; as_dly_n = 1'b0; dtack_n = 1'b0;
    repeat (2) @(negedge clk_slow);
    dtack_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_slow); #SETTLE;
      expect_pair("R5 early dtack rejected", 2'b11);
    end
    release_cycle("early");

    // R10: no strobe, dtack and flag both active.
    @(negedge clk_slow);
    dtack_n = 1'b0; term_flag = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk_slow); #SETTLE;
      expect_pair("R10 no strobe no ack", 2'b11);
    end
    dtack_n = 1'b1; term_flag = 1'b0;

    // R1: merging of coprocessor and static RAM acknowledges.
    @(negedge clk_slow);
    cp_dsack1_n = 1'b0; cp_dsack0_n = 1'b0; #5;
    expect_pair("R1 coprocessor 32-bit", 2'b00);
    cp_dsack0_n = 1'b1; #5;
    expect_pair("R1 coprocessor 16-bit", 2'b01);
    cp_dsack1_n = 1'b1; sram_dsack0_n = 1'b0; #5;
    expect_pair("R1 sram 8-bit", 2'b10);
    sram_dsack1_n = 1'b0; sram_dsack0_n = 1'b1; cp_dsack0_n = 1'b0; #5;
    expect_pair("R1 mixed sources 32-bit", 2'b00);
    sram_dsack1_n = 1'b1; cp_dsack0_n = 1'b1; #5;
    expect_pair("R1 all released wait", 2'b11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule